// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block produces the memory address for a load or store. It also produces the updated value of the base register when the access uses indexing with base update. It takes a base value and an offset. The offset can be an immediate, an index register, or an index register shifted left. The offset is added to the base or subtracted from it. A mode select then chooses which value goes out as the address and whether the base register is updated. All arithmetic is 32-bit and wraps modulo 2^32. No overflow is reported.

The datapath is combinational. The parameter `REG_OUT` adds a register stage on the outputs. With the default `REG_OUT = 1`, each result appears one clock after its operands. The memory access, alignment checks, the register file and instruction decode all stay outside this block.

Top module: `lsu_addr_gen`

## Requirements
- R1: Mode `mode_i = 2'b00` (plain offset) gives `addr_o` = base ± offset, and `wb_en_o` is 0.
- R2: Mode `2'b01` (pre-indexed) gives `addr_o` and `wb_val_o` both equal to base ± offset, and `wb_en_o` is 1.
- R3: Mode `2'b10` (post-indexed) gives `addr_o` equal to the unmodified base and `wb_val_o` = base ± offset, and `wb_en_o` is 1.
- R4: `sub_i = 0` adds the offset to the base. `sub_i = 1` subtracts the offset from the base.
- R5: `src_i` selects the offset:
  - `2'b00`: the immediate, zero-extended to 32 bits.
  - `2'b01`: the index register.
  - `2'b10`: the index register shifted left by `shamt_i`.
  - `2'b11`: the same as `2'b00`.
- R6: The shift amount is 5 bits (0 to 31). Bits shifted past bit 31 are discarded. A shift of 0 passes the index through unchanged.
- R7: Sums and differences wrap modulo 2^32. For example, 0xFFFFFFF0 + 0x20 = 0x10 and 0 − 1 = 0xFFFFFFFF.
- R8: Mode `2'b11` behaves exactly like plain offset mode, with no writeback.
- R9: With `REG_OUT = 1`, outputs update one clock after their inputs are presented. While `rst` is high at a clock edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | IMM_W (12) | Immediate offset, zero-extended |
| shamt_i | input | SH_W (5) | Left-shift amount applied to the index |
| src_i | input | 2 | Offset source select |
| sub_i | input | 1 | 1 = subtract the offset, 0 = add it |
| mode_i | input | 2 | Indexing mode select |
| addr_o | output | 32 | Effective address |
| wb_val_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base writeback enable |

## Verification
The block keeps no state beyond the output register, so every fault shows on the very next sampled result. A wrong offset source or shift shows up as a bad `wb_val_o` in every mode. A swapped mode shows up in one of three ways: the address equals the sum when it should equal the base, writeback is enabled in offset mode, or the address differs from the writeback value in pre-indexed mode. A stuck output register shows up one clock after reset releases, as a value that fails to follow the inputs.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        MODE_OFS  = 2'b00,
        MODE_PRE  = 2'b01,
        MODE_POST = 2'b10,
        MODE_RSV  = 2'b11
    } agu_mode_e;

    typedef enum logic [1:0] {
        SRC_IMM   = 2'b00,
        SRC_IDX   = 2'b01,
        SRC_SHIFT = 2'b10,
        SRC_ALT   = 2'b11
    } agu_src_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_val;
        logic            wb_en;
    } agu_res_t;

    // Modes 01 and 10 update the base register.
    function automatic logic mode_writes_base(agu_mode_e m);
        return (m == MODE_PRE) || (m == MODE_POST);
    endfunction

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int IMM_W = 12,
    parameter int SH_W  = 5
) (
    input  logic [XLEN-1:0]  index_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  agu_src_e         src_i,
    output logic [XLEN-1:0]  off_o
);

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] idx_shl;

    assign imm_ext = XLEN'(imm_i);
    assign idx_shl = index_i << shamt_i;

    always_comb begin
        unique case (src_i)
            SRC_IDX:   off_o = index_i;
            SRC_SHIFT: off_o = idx_shl;
            default:   off_o = imm_ext;
        endcase
    end

    // A zero shift must leave the index unchanged.
    always_comb begin
        if (src_i == SRC_SHIFT && shamt_i == '0)
            assert_zero_shift_passthru_R6: assert (off_o == index_i);
    end

endmodule

// File: rtl/agu_adder.sv
module agu_adder
    import agu_pkg::*;
(
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] off_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o
);

    always_comb begin
        if (sub_i) sum_o = base_i - off_i;
        else       sum_o = base_i + off_i;
    end

    // Undoing the operation must recover the base, which holds only with modulo-2^32 wrap.
    logic [XLEN-1:0] undo;
    assign undo = sub_i ? (sum_o + off_i) : (sum_o - off_i);

    always_comb begin
        assert_wrap_inverse_R7: assert (undo == base_i);
    end

endmodule

// File: rtl/agu_mode_mux.sv
module agu_mode_mux
    import agu_pkg::*;
(
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] sum_i,
    input  agu_mode_e       mode_i,
    output agu_res_t        res_o
);

    always_comb begin
        res_o.wb_val = sum_i;
        res_o.wb_en  = mode_writes_base(mode_i);
        res_o.addr   = (mode_i == MODE_POST) ? base_i : sum_i;
    end

    always_comb begin
        if (mode_i == MODE_OFS || mode_i == MODE_RSV)
            assert_offset_no_wb_R1: assert (!res_o.wb_en);
        if (mode_i == MODE_PRE)
            assert_pre_same_value_R2: assert (res_o.addr == res_o.wb_val && res_o.wb_en);
        if (mode_i == MODE_POST)
            assert_post_base_addr_R3: assert (res_o.addr == base_i && res_o.wb_en);
    end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import agu_pkg::*;
#(
    parameter int IMM_W   = 12,
    parameter int SH_W    = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      base_i,
    input  logic [31:0]      index_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SH_W-1:0]  shamt_i,
    input  logic [1:0]       src_i,
    input  logic             sub_i,
    input  logic [1:0]       mode_i,
    output logic [31:0]      addr_o,
    output logic [31:0]      wb_val_o,
    output logic             wb_en_o
);

    logic [XLEN-1:0] off;
    logic [XLEN-1:0] sum;
    agu_res_t        res;

    agu_offset_sel #(.IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .index_i (index_i),
        .imm_i   (imm_i),
        .shamt_i (shamt_i),
        .src_i   (agu_src_e'(src_i)),
        .off_o   (off)
    );

    agu_adder u_add (
        .base_i (base_i),
        .off_i  (off),
        .sub_i  (sub_i),
        .sum_o  (sum)
    );

    agu_mode_mux u_mux (
        .base_i (base_i),
        .sum_i  (sum),
        .mode_i (agu_mode_e'(mode_i)),
        .res_o  (res)
    );

    generate
        if (REG_OUT) begin : g_reg
            agu_res_t res_q;

            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res;
            end

            assign addr_o   = res_q.addr;
            assign wb_val_o = res_q.wb_val;
            assign wb_en_o  = res_q.wb_en;

            // Registered writeback enable must trace back to a base-updating mode one cycle earlier.
            assert_wb_latency_R9: assert property (@(posedge clk) disable iff (rst)
                wb_en_o |-> ($past(mode_i) == 2'b01 || $past(mode_i) == 2'b10));
        end else begin : g_comb
            assign addr_o   = res.addr;
            assign wb_val_o = res.wb_val;
            assign wb_en_o  = res.wb_en;
        end
    endgenerate

endmodule

// File: tb/sim_lsu_addr_gen.sv
`timescale 1ns/1ps
module sim_lsu_addr_gen;

    localparam int IMM_W = 12;
    localparam int SH_W  = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [31:0]      base_i = '0;
    logic [31:0]      index_i = '0;
    logic [IMM_W-1:0] imm_i = '0;
    logic [SH_W-1:0]  shamt_i = '0;
    logic [1:0]       src_i = '0;
    logic             sub_i = 1'b0;
    logic [1:0]       mode_i = '0;
    logic [31:0]      addr_o;
    logic [31:0]      wb_val_o;
    logic             wb_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_addr_gen #(.IMM_W(IMM_W), .SH_W(SH_W), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .base_i(base_i), .index_i(index_i), .imm_i(imm_i),
        .shamt_i(shamt_i), .src_i(src_i), .sub_i(sub_i), .mode_i(mode_i),
        .addr_o(addr_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o)
    );

    function automatic logic [31:0] ref_off(logic [31:0] idx, logic [IMM_W-1:0] imm,
                                            logic [SH_W-1:0] sh, logic [1:0] src);
        case (src)
            2'b01:   return idx;
            2'b10:   return idx << sh;
            default: return {{(32-IMM_W){1'b0}}, imm};
        endcase
    endfunction

    function automatic logic [31:0] ref_sum(logic [31:0] b, logic [31:0] o, logic s);
        return s ? (b - o) : (b + o);
    endfunction

    task automatic check(string tag, logic [31:0] a, logic [31:0] ea,
                         logic [31:0] w, logic [31:0] ew, logic we, logic ewe);
        checks++;
        if (a !== ea || w !== ew || we !== ewe) begin
            errors++;
            $display("FAIL %s: addr=%h wb=%h en=%b expected addr=%h wb=%h en=%b",
                     tag, a, w, we, ea, ew, ewe);
        end
    endtask

    // Drive at negedge; result is registered at the next posedge; sample at the following negedge.
    task automatic run(string tag, logic [31:0] b, logic [31:0] idx, logic [IMM_W-1:0] imm,
                       logic [SH_W-1:0] sh, logic [1:0] src, logic s, logic [1:0] m);
        logic [31:0] sm;
        logic [31:0] ea;
        logic        ewe;
        base_i = b; index_i = idx; imm_i = imm; shamt_i = sh;
        src_i = src; sub_i = s; mode_i = m;
        sm  = ref_sum(b, ref_off(idx, imm, sh, src), s);
        ewe = (m == 2'b01 || m == 2'b10);
        ea  = (m == 2'b10) ? b : sm;
        @(negedge clk);
        check(tag, addr_o, ea, wb_val_o, sm, wb_en_o, ewe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        base_i = 32'hDEAD_BEEF; index_i = 32'h1234_5678; mode_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R9 reset clear", addr_o, '0, wb_val_o, '0, wb_en_o, 1'b0);
        rst = 1'b0;

        run("R1 offset add imm",      32'h1000, 32'h0, 12'h010, 5'd0, 2'b00, 1'b0, 2'b00);
        run("R2 pre add idx",         32'h2000, 32'h40, 12'h0, 5'd0, 2'b01, 1'b0, 2'b01);
        run("R3 post sub idx",        32'h3000, 32'h100, 12'h0, 5'd0, 2'b01, 1'b1, 2'b10);
        run("R4 subtract imm",        32'h500, 32'h0, 12'hFFF, 5'd0, 2'b00, 1'b1, 2'b01);
        run("R5 src 11 as imm",       32'h10, 32'hFFFF, 12'h008, 5'd3, 2'b11, 1'b0, 2'b00);
        run("R6 shift 31",            32'h0, 32'h3, 12'h0, 5'd31, 2'b10, 1'b0, 2'b01);
        run("R6 shift 0",             32'h100, 32'hABCD, 12'h0, 5'd0, 2'b10, 1'b0, 2'b00);
        run("R6 shift 4",             32'h100, 32'hF000_0001, 12'h0, 5'd4, 2'b10, 1'b1, 2'b10);
        run("R7 wrap add",            32'hFFFF_FFF0, 32'h0, 12'h020, 5'd0, 2'b00, 1'b0, 2'b01);
        run("R7 wrap sub",            32'h0, 32'h1, 12'h0, 5'd0, 2'b01, 1'b1, 2'b00);
        run("R8 mode 11 no wb",       32'h4000, 32'h8, 12'h0, 5'd0, 2'b01, 1'b0, 2'b11);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic [1:0] sr;
            m  = 2'($urandom_range(0, 3));
            sr = 2'($urandom_range(0, 3));
            run(m == 2'b00 ? "R1 random" : m == 2'b01 ? "R2 random" :
                m == 2'b10 ? "R3 random" : "R8 random",
                $urandom, $urandom, IMM_W'($urandom), SH_W'($urandom),
                sr, 1'($urandom), m);
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset mid-run", addr_o, '0, wb_val_o, '0, wb_en_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule